// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronous Halt

This block turns the system clock into count enables for a group of timer channels that share one prescaler. A single free-running counter provides single-cycle strobes at divide ratios 1, 8, 64, 256 and 1024. Each channel has its own three-bit clock selector. The selector can pick one of these strobes, pick an edge of that channel's external pin, or turn the channel off. The timer counters that consume the enables sit outside this block.

A small control register coordinates the channels. While its halt bit is set, every enable is held low. Its prescaler-clear bit then stays set and keeps the shared counter at zero, so the software can configure all the timers without any of them moving. When the halt bit is written back to zero, hardware drops the clear bits. The shared counter and every channel then restart from the same cycle, with their phases aligned.

Top module: `tmr_prescale_share`

## Requirements
- R1: After reset the control readback is zero, `alt_rst` is low and no tick is issued while every selector is 000.
- R2: Selector value 000 keeps that channel's tick low in every cycle.
- R3: Selector value 001 gives a tick in every cycle in which neither the halt bit (control bit 7) nor the prescaler-clear bit (control bit 0) is set.
- R4: Selector values 010, 011, 100 and 101 give one tick every 8, 64, 256 and 1024 cycles. Count the cycles k from the first cycle in which the prescaler is free after a clear. A channel ticks in cycle k exactly when (k mod N) equals N-1. All channels therefore share the same phase.
- R5: Selector value 111 ticks on rising edges of the channel's external pin, and value 110 ticks on falling edges. The tick appears SYNC_STAGES cycles after the pin changes. The pin's use elsewhere as an output has no bearing on this.
- R6: While control bit 7 (halt) is set, every channel's tick is low, whatever the selectors and the pins are doing.
- R7: Control bit 0 (prescaler clear) holds the shared counter at zero and suppresses selectors 001 to 101 in every cycle in which it is set. While bit 7 is set, bit 0 stays set until it is written.
- R8: In any cycle with no write and bit 7 clear, control bits 1 and 0 are zero in the next cycle. Writing a 1 to bit 0 with bit 7 clear therefore clears the prescaler for exactly one cycle.
- R9: Control bit 1 drives `alt_rst`, a clear request for a neighbouring prescaler. It is stored and self-cleared by the same rules as bit 0.
- R10: The control readback shows bit 7, bit 1 and bit 0 as written, and every other bit reads as zero.
- R11: For a steady selector of 010 or above, a tick never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | REG_W | Control write data (bit 7 halt, bit 1 neighbour clear, bit 0 prescaler clear) |
| ctl_q | output | REG_W | Control register readback |
| alt_rst | output | 1 | Neighbouring prescaler clear request (control bit 1) |
| sel | input | 3*NUM_CH | Per-channel clock selector, channel c in bits 3c+2..3c |
| ext_pin | input | NUM_CH | Per-channel external clock pin (asynchronous) |
| tick | output | NUM_CH | Per-channel single-cycle count enable |

## Verification
The assertions take two things for granted. First, a channel's selector is steady while its tick property is judged; the one-shot property excuses any cycle in which the selector changes. Second, no write lands in the cycle in which the self-clear and hold properties apply. The stimulus changes selectors only while the halt bit is set, or between measurement windows. It issues control writes one at a time, with idle cycles between them. The external pins are held low through reset and toggled no faster than once every three cycles, so each edge's tick is seen on its own.

// File: rtl/tps_pkg.sv
package tps_pkg;

   // clock selector encodings
   typedef enum logic [2:0] {
      CS_OFF      = 3'd0,
      CS_DIV1     = 3'd1,
      CS_DIV8     = 3'd2,
      CS_DIV64    = 3'd3,
      CS_DIV256   = 3'd4,
      CS_DIV1024  = 3'd5,
      CS_EXT_FALL = 3'd6,
      CS_EXT_RISE = 3'd7
   } clk_sel_e;

   localparam int NUM_TAPS = 5;
   localparam int SEL_W    = 3;

   // log2 of the divide ratio behind each tap
   function automatic int tap_shift(input int idx);
      case (idx)
         0:       return 0;
         1:       return 3;
         2:       return 6;
         3:       return 8;
         default: return 10;
      endcase
   endfunction

   // stored control state
   typedef struct packed {
      logic       halt;
      logic [1:0] clr;
   } ctl_t;

endpackage

// File: rtl/tps_ctl.sv
module tps_ctl
   import tps_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             halt,
   output logic             psc_clr,
   output logic             alt_clr
);

   localparam int HALT_BIT = REG_W - 1;

   ctl_t st_q;
   logic unused_wbits;

   assign unused_wbits = ^wdata[HALT_BIT-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (wr_en) begin
         st_q.halt <= wdata[HALT_BIT];
         st_q.clr  <= wdata[1:0];
      end else if (!st_q.halt) begin
         // clear requests only persist under halt
         st_q.clr <= '0;
      end
   end

   always_comb begin
      rdata           = '0;
      rdata[HALT_BIT] = st_q.halt;
      rdata[1:0]      = st_q.clr;
   end

   assign halt    = st_q.halt;
   assign psc_clr = st_q.clr[0];
   assign alt_clr = st_q.clr[1];

endmodule

// File: rtl/tps_divider.sv
module tps_divider
   import tps_pkg::*;
#(
   parameter int DIV_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   output logic [NUM_TAPS-1:0] taps
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      localparam int SH = tap_shift(t);
      if (SH > DIV_W) begin : g_bad
         $error("tps_divider: DIV_W too narrow for tap %0d", t);
      end else if (SH == 0) begin : g_direct
         assign taps[t] = !clr;
      end else begin : g_roll
         // strobe in the cycle the low SH bits are about to wrap
         assign taps[t] = !clr && (&cnt_q[SH-1:0]);
      end
   end

endmodule

// File: rtl/tps_edge.sv
module tps_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   // STAGES synchroniser flops plus one history flop
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin};
   end

   assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/tps_sel.sv
module tps_sel
   import tps_pkg::*;
(
   input  logic [SEL_W-1:0]    sel,
   input  logic [NUM_TAPS-1:0] taps,
   input  logic                rise,
   input  logic                fall,
   input  logic                halt,
   output logic                tick
);

   logic pick;

   always_comb begin
      unique case (clk_sel_e'(sel))
         CS_OFF:      pick = 1'b0;
         CS_DIV1:     pick = taps[0];
         CS_DIV8:     pick = taps[1];
         CS_DIV64:    pick = taps[2];
         CS_DIV256:   pick = taps[3];
         CS_DIV1024:  pick = taps[4];
         CS_EXT_FALL: pick = fall;
         CS_EXT_RISE: pick = rise;
         default:     pick = 1'b0;
      endcase
   end

   assign tick = pick & ~halt;

endmodule

// File: rtl/tmr_prescale_share.sv
module tmr_prescale_share
   import tps_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int REG_W       = 8,
   parameter int DIV_W       = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ctl_wr,
   input  logic [REG_W-1:0]        ctl_wdata,
   output logic [REG_W-1:0]        ctl_q,
   output logic                    alt_rst,
   input  logic [NUM_CH*SEL_W-1:0] sel,
   input  logic [NUM_CH-1:0]       ext_pin,
   output logic [NUM_CH-1:0]       tick
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("tmr_prescale_share: NUM_CH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_prescale_share: SYNC_STAGES must be at least 2");
   end
   if (REG_W < 8) begin : g_bad_reg
      $error("tmr_prescale_share: REG_W must be at least 8");
   end

   logic                halt;
   logic                psc_clr;
   logic [NUM_TAPS-1:0] taps;

   tps_ctl #(.REG_W(REG_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctl_wr),
      .wdata   (ctl_wdata),
      .rdata   (ctl_q),
      .halt    (halt),
      .psc_clr (psc_clr),
      .alt_clr (alt_rst)
   );

   tps_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (psc_clr),
      .taps  (taps)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic rise;
      logic fall;

      tps_edge #(.STAGES(SYNC_STAGES)) u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (ext_pin[c]),
         .rise  (rise),
         .fall  (fall)
      );

      tps_sel u_sel (
         .sel  (sel[c*SEL_W +: SEL_W]),
         .taps (taps),
         .rise (rise),
         .fall (fall),
         .halt (halt),
         .tick (tick[c])
      );
   end

endmodule

// File: rtl/tps_chk.sv
module tps_chk #(
   parameter int NUM_CH = 2,
   parameter int REG_W  = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ctl_wr,
   input logic [REG_W-1:0]    ctl_q,
   input logic [NUM_CH*3-1:0] sel,
   input logic [NUM_CH-1:0]   tick
);

   localparam int HB = REG_W - 1;

   // R6
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[HB] |-> (tick == '0));

   // R7
   clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[HB] && ctl_q[0] && !ctl_wr) |=> ctl_q[0]);

   // R8
   clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[HB] && !ctl_wr) |=> (ctl_q[1:0] == 2'b00));

   // R10
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[HB-1:2] == '0);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R2
      off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel[c*3 +: 3] == 3'd0) |-> !tick[c]);

      // R3
      undiv_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel[c*3 +: 3] == 3'd1 && !ctl_q[HB] && !ctl_q[0]) |-> tick[c]);

      // R11
      one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel[c*3 +: 3] >= 3'd2 && tick[c]) |=> !(tick[c] && $stable(sel[c*3 +: 3])));
   end

endmodule

bind tmr_prescale_share tps_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ctl_wr (ctl_wr),
   .ctl_q  (ctl_q),
   .sel    (sel),
   .tick   (tick)
);

// File: tb/tmr_prescale_share_test.sv
module tmr_prescale_share_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ctl_wr;
   logic [7:0] ctl_wdata;
   logic [7:0] ctl_q;
   logic       alt_rst;
   logic [5:0] sel;
   logic [1:0] ext_pin;
   logic [1:0] tick;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   tmr_prescale_share uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .ctl_q     (ctl_q),
      .alt_rst   (alt_rst),
      .sel       (sel),
      .ext_pin   (ext_pin),
      .tick      (tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_ctl(input logic [7:0] v);
      @(negedge clk);
      ctl_wr    = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_wr    = 1'b0;
      ctl_wdata = 8'h00;
   endtask

   function automatic bit exp_div(input int s, input int k);
      case (s)
         0:       return 1'b0;
         1:       return 1'b1;
         2:       return (k % 8) == 7;
         3:       return (k % 64) == 63;
         4:       return (k % 256) == 255;
         5:       return (k % 1024) == 1023;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string req_of(input int s);
      if (s == 0)      return "R2 off";
      else if (s == 1) return "R3 undivided";
      else             return "R4 divided";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int s1;
      bit r0;
      bit f1;
      bit nv0;
      bit nv1;
      int hold;

      rst_n     = 1'b0;
      ctl_wr    = 1'b0;
      ctl_wdata = 8'h00;
      sel       = 6'd0;
      ext_pin   = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(ctl_q == 8'h00, "R1 ctl readback", ctl_q, 0);
      chk(alt_rst == 1'b0, "R1 alt_rst", alt_rst, 0);
      for (int k = 0; k < 16; k++) begin
         chk(tick == 2'b00, "R1 tick idle", tick, 0);
         @(negedge clk);
      end

      // R2 R3 R4 sweep of divided selectors on both channels
      for (int s0 = 0; s0 < 6; s0++) begin
         s1 = 5 - s0;
         write_ctl(8'h81);
         sel = {3'(s1), 3'(s0)};
         for (int k = 0; k < 4; k++) begin
            chk(tick == 2'b00, "R6 halt", tick, 0);
            chk(ctl_q == 8'h81, "R7 clear held", ctl_q, 8'h81);
            @(negedge clk);
         end
         write_ctl(8'h00);
         chk(ctl_q == 8'h00, "R8 release", ctl_q, 0);
         for (int k = 0; k < 2048; k++) begin
            chk(tick[0] == exp_div(s0, k), req_of(s0), tick[0], exp_div(s0, k));
            chk(tick[1] == exp_div(s1, k), req_of(s1), tick[1], exp_div(s1, k));
            @(negedge clk);
         end
      end

      // R7 one-cycle clear while running
      write_ctl(8'h81);
      sel = {3'd1, 3'd2};
      write_ctl(8'h00);
      repeat (13) @(negedge clk);
      write_ctl(8'h01);
      chk(ctl_q == 8'h01, "R8 pulse stored", ctl_q, 1);
      chk(tick == 2'b00, "R7 clear suppresses taps", tick, 0);
      @(negedge clk);
      chk(ctl_q == 8'h00, "R8 self clear", ctl_q, 0);
      for (int k = 0; k < 40; k++) begin
         chk(tick[0] == exp_div(2, k), "R7 restart phase", tick[0], exp_div(2, k));
         chk(tick[1] == 1'b1, "R3 after clear", tick[1], 1);
         @(negedge clk);
      end

      // R9 R10 readback and neighbour clear
      write_ctl(8'hFF);
      chk(ctl_q == 8'h83, "R10 readback", ctl_q, 8'h83);
      chk(alt_rst == 1'b1, "R9 alt set", alt_rst, 1);
      @(negedge clk);
      chk(alt_rst == 1'b1, "R9 alt held", alt_rst, 1);
      write_ctl(8'h02);
      chk(ctl_q == 8'h02, "R9 alt pulse", ctl_q, 2);
      chk(alt_rst == 1'b1, "R9 alt pulse", alt_rst, 1);
      @(negedge clk);
      chk(ctl_q == 8'h00, "R8 alt self clear", ctl_q, 0);
      chk(alt_rst == 1'b0, "R9 alt cleared", alt_rst, 0);

      // R5 external edges: ch0 rising, ch1 falling
      sel = {3'd6, 3'd7};
      repeat (4) @(negedge clk);
      for (int step = 0; step < 24; step++) begin
         nv0  = (step % 3) != 0;
         nv1  = (step % 4) < 2;
         r0   = !ext_pin[0] && nv0;
         f1   = ext_pin[1] && !nv1;
         hold = 3 + (step % 3);
         ext_pin = {nv1, nv0};
         @(negedge clk);
         chk(tick == 2'b00, "R5 sync latency", tick, 0);
         @(negedge clk);
         chk(tick[0] == r0, "R5 rising edge", tick[0], r0);
         chk(tick[1] == f1, "R5 falling edge", tick[1], f1);
         for (int h = 2; h < hold; h++) begin
            @(negedge clk);
            chk(tick == 2'b00, "R11 single pulse", tick, 0);
         end
         @(negedge clk);
      end

      // R6 external edges ignored during halt
      write_ctl(8'h80);
      ext_pin = ~ext_pin;
      for (int k = 0; k < 5; k++) begin
         chk(tick == 2'b00, "R6 halt external", tick, 0);
         @(negedge clk);
      end
      ext_pin = ~ext_pin;
      for (int k = 0; k < 5; k++) begin
         chk(tick == 2'b00, "R6 halt external", tick, 0);
         @(negedge clk);
      end
      write_ctl(8'h00);
      chk(ctl_q == 8'h00, "R8 final release", ctl_q, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule